// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block manages sixteen general-purpose pins, arranged as two banks of eight. A host reaches every setting through a small byte-wide register bus: an 8-bit address, 8-bit write data, a write strobe and a read strobe. Read data is combinational. Each pin has two registers. The output-control register sets direction, drive style (push-pull or open-drain), the output level and the pull-resistor selection. The pull-resistor selection leaves the block as plain control bits for the pad ring. The input-control register returns the synchronized pin level and holds the pin's edge-detection mode.

Every pin can flag a falling, rising or either-edge event. Events collect in a per-bank pending register that the host clears by writing ones. Two mask registers exist per bank. The active mask gates the single registered interrupt line to the host. The standby mask is storage only, kept for a low-power controller elsewhere on the chip.

Top module: `gpio_irq_ctl`

## Requirements
- R1: The output-control register of in-bank pin i sits at 0x2B+i for bank 0 and 0x3B+i for bank 1. It holds bit 5 direction (1 = output), bit 4 drive style (1 = open-drain), bit 3 pull enable, bits 2:1 pull select and bit 0 output value. Bits 7:6 read as 0.
- R2: The input-control register of pin i sits at 0x33+i (bank 0) and 0x43+i (bank 1). Bit 0 reads the pin level after a two-flop synchronizer, bits 2:1 read back the edge mode and the other bits read 0. Writes to bit 0 have no effect.
- R3: With the direction bit at 1 and push-pull drive, pad_oe is 1 and pad_out equals the output value. With the direction bit at 0, pad_oe is 0.
- R4: In open-drain drive with the direction bit at 1, pad_oe is 1 only while the output value is 0, and pad_out is always 0.
- R5: pull_en[p] is the pull-enable bit of pin p. pull_sel[2p+1:2p] is its pull-select field, coded 00 strong down, 01 strong up, 10 weak down, 11 weak up.
- R6: Edge mode 00 detects nothing, 01 falling, 10 rising, 11 both. A detected edge sets the pin's pending bit on the third rising clock after the pin changes.
- R7: Pending registers are at 0x0B (bank 0) and 0x0C (bank 1), with bit n for in-bank pin n. Writing 1 clears a bit and writing 0 leaves it unchanged.
- R8: When a new edge and a clearing write hit the same pending bit in one cycle, the bit stays set.
- R9: Active masks are at 0x19 (bank 0) and 0x1A (bank 1), where 1 masks the pin. Pending bits set even while masked. host_irq is the OR of pending AND NOT active mask over all pins, registered one cycle.
- R10: Standby masks are at 0x1B (bank 0) and 0x1C (bank 1), readable and writable, with no effect on host_irq.
- R11: Reset clears every register: all pins are inputs, no edge detection, nothing pending, host_irq low. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 16 | Asynchronous pin levels from the pads |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output level |
| pull_en | output | 16 | Per-pin pull-resistor enable |
| pull_sel | output | 32 | Two pull-select bits per pin |
| host_irq | output | 1 | Registered interrupt request to the host |

## Verification
The pending-register properties assume that a clearing write and an edge on the same bit can coincide. They also assume the write strobe is a clean single-cycle pulse sampled on the clock. The bench therefore changes bus signals and pins only at falling clock edges, holding each write for exactly one rising edge. The edge properties assume pin inputs may be fully asynchronous, so the bench moves pins freely and sets its read-back timing from the fixed synchronizer depth. One sequence deliberately lines a clearing write up with the capture cycle of a new edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam logic [7:0] OUT_BASE   = 8'h2B;
   localparam logic [7:0] IN_BASE    = 8'h33;
   localparam logic [7:0] PEND_BASE  = 8'h0B;
   localparam logic [7:0] MACT_BASE  = 8'h19;
   localparam logic [7:0] MSBY_BASE  = 8'h1B;
   localparam int         BANK_STEP  = 16;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   // field order equals register bit order 5..0
   typedef struct packed {
      logic       dir;
      logic       odrain;
      logic       pull_en;
      logic [1:0] pull_sel;
      logic       val;
   } pin_ctl_t;

   function automatic logic [7:0] out_addr(int b, int i);
      return OUT_BASE + 8'(b * BANK_STEP + i);
   endfunction

   function automatic logic [7:0] in_addr(int b, int i);
      return IN_BASE + 8'(b * BANK_STEP + i);
   endfunction

   function automatic logic [7:0] bank_addr(logic [7:0] base, int b);
      return base + 8'(b);
   endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [5:0] ctl_wdata,
   input  logic       mode_we,
   input  logic [1:0] mode_wdata,
   input  logic       pin_async,
   output pin_ctl_t   ctl,
   output edge_mode_e mode,
   output logic       level,
   output logic       hit,
   output logic       pad_oe,
   output logic       pad_out
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pin_cell: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         mode   <= EDGE_OFF;
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         if (ctl_we)  ctl  <= pin_ctl_t'(ctl_wdata);
         if (mode_we) mode <= edge_mode_e'(mode_wdata);
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign level = sync_q[SYNC_STAGES-1];

   always_comb begin
      unique case (mode)
         EDGE_FALL: hit = prev_q & ~level;
         EDGE_RISE: hit = ~prev_q & level;
         EDGE_BOTH: hit = prev_q ^ level;
         default:   hit = 1'b0;
      endcase
   end

   always_comb begin
      if (ctl.odrain) begin
         pad_oe  = ctl.dir & ~ctl.val;
         pad_out = 1'b0;
      end else begin
         pad_oe  = ctl.dir;
         pad_out = ctl.val;
      end
   end

   // R6
   edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_OFF) |-> !hit);

   // R4
   od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.odrain && pad_oe) |-> !pad_out);

   // R3
   in_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.dir |-> !pad_oe);

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hits,
   input  logic [WIDTH-1:0] wdata,
   input  logic             clr_we,
   input  logic             mact_we,
   input  logic             msby_we,
   output logic [WIDTH-1:0] pending,
   output logic [WIDTH-1:0] mask_act,
   output logic [WIDTH-1:0] mask_sby,
   output logic             irq_req
);

   logic [WIDTH-1:0] clr_bits;

   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= '0;
         mask_act <= '0;
         mask_sby <= '0;
      end else begin
         pending <= (pending & ~clr_bits) | hits;
         if (mact_we) mask_act <= wdata;
         if (msby_we) mask_sby <= wdata;
      end
   end

   assign irq_req = |(pending & ~mask_act);

   // R6 R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hits != '0) |=> ((pending & $past(hits)) == $past(hits)));

   // R7
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((pending & $past(wdata & ~hits)) == '0));

   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && hits == '0) |=> $stable(pending));

endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_PINS   = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_PINS   = NUM_BANKS * BANK_PINS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            bus_addr,
   input  logic [7:0]            bus_wdata,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   output logic [7:0]            bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pull_en,
   output logic [2*NUM_PINS-1:0] pull_sel,
   output logic                  host_irq
);

   if (BANK_PINS != 8) begin : g_bad_width
      $error("gpio_irq_ctl: BANK_PINS must equal the 8-bit bus width");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("gpio_irq_ctl: address plan holds one or two banks");
   end

   pin_ctl_t            ctl_v  [NUM_PINS];
   edge_mode_e          mode_v [NUM_PINS];
   logic [NUM_PINS-1:0] level_v;
   logic [NUM_PINS-1:0] hit_v;

   logic [BANK_PINS-1:0] pend_v [NUM_BANKS];
   logic [BANK_PINS-1:0] mact_v [NUM_BANKS];
   logic [BANK_PINS-1:0] msby_v [NUM_BANKS];
   logic [NUM_BANKS-1:0] req_v;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar i = 0; i < BANK_PINS; i++) begin : g_pin
         localparam int P = b * BANK_PINS + i;

         gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_we     (bus_wr && bus_addr == out_addr(b, i)),
            .ctl_wdata  (bus_wdata[5:0]),
            .mode_we    (bus_wr && bus_addr == in_addr(b, i)),
            .mode_wdata (bus_wdata[2:1]),
            .pin_async  (pin_in[P]),
            .ctl        (ctl_v[P]),
            .mode       (mode_v[P]),
            .level      (level_v[P]),
            .hit        (hit_v[P]),
            .pad_oe     (pad_oe[P]),
            .pad_out    (pad_out[P])
         );

         assign pull_en[P]          = ctl_v[P].pull_en;
         assign pull_sel[2*P +: 2]  = ctl_v[P].pull_sel;
      end

      gpio_bank_irq #(.WIDTH(BANK_PINS)) u_irq (
         .clk      (clk),
         .rst_n    (rst_n),
         .hits     (hit_v[b*BANK_PINS +: BANK_PINS]),
         .wdata    (bus_wdata),
         .clr_we   (bus_wr && bus_addr == bank_addr(PEND_BASE, b)),
         .mact_we  (bus_wr && bus_addr == bank_addr(MACT_BASE, b)),
         .msby_we  (bus_wr && bus_addr == bank_addr(MSBY_BASE, b)),
         .pending  (pend_v[b]),
         .mask_act (mact_v[b]),
         .mask_sby (msby_v[b]),
         .irq_req  (req_v[b])
      );
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == bank_addr(PEND_BASE, b)) bus_rdata = pend_v[b];
            if (bus_addr == bank_addr(MACT_BASE, b)) bus_rdata = mact_v[b];
            if (bus_addr == bank_addr(MSBY_BASE, b)) bus_rdata = msby_v[b];
            for (int i = 0; i < BANK_PINS; i++) begin
               if (bus_addr == out_addr(b, i))
                  bus_rdata = {2'b00, ctl_v[b*BANK_PINS+i]};
               if (bus_addr == in_addr(b, i))
                  bus_rdata = {5'b00000, mode_v[b*BANK_PINS+i],
                               level_v[b*BANK_PINS+i]};
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_irq <= 1'b0;
      else        host_irq <= |req_v;
   end

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> $past(|req_v));

   // R9
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_v) |=> host_irq);

endmodule

// File: tb/gpio_irq_ctl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pad_oe;
   logic [15:0] pad_out;
   logic [15:0] pull_en;
   logic [31:0] pull_sel;
   logic        host_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pull_en(pull_en), .pull_sel(pull_sel), .host_irq(host_irq)
   );

   // {address, write data, expected read-back}
   localparam logic [23:0] VEC [0:8] = '{
      24'h2E_FF_3F,   // R1 bank 0 pin 3, top bits dropped
      24'h42_15_15,   // R1 bank 1 pin 7
      24'h36_FF_06,   // R2 level bit not writable, both edges
      24'h45_04_04,   // R2 bank 1 pin 2 rising
      24'h19_A5_A5,   // R9 active mask bank 0
      24'h1C_3C_3C,   // R10 standby mask bank 1
      24'h1B_FF_FF,   // R10 standby mask bank 0
      24'h50_77_00,   // R11 unmapped
      24'h0B_FF_00    // R7 clearing nothing pending
   };

   function automatic string vtag(int k);
      case (k)
         0, 1:    return "R1";
         2, 3:    return "R2";
         4:       return "R9";
         5, 6:    return "R10";
         7:       return "R11";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(tag, {24'h0, bus_rdata}, {24'h0, exp});
      bus_rd = 1'b0;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R11 reset state
      chk("R11 host_irq", host_irq, 0);
      chk("R11 pad_oe", pad_oe, 0);
      rd_chk("R11 ctl reset", 8'h2B, 8'h00);
      rd_chk("R11 pending reset", 8'h0B, 8'h00);

      for (int k = 0; k < 9; k++) begin
         wr(VEC[k][23:16], VEC[k][15:8]);
         rd_chk(vtag(k), VEC[k][23:16], VEC[k][7:0]);
      end

      // R4 pin 3 is 0x3F: open-drain, value 1 -> released
      chk("R4 od high oe", pad_oe[3], 0);
      chk("R4 od high out", pad_out[3], 0);
      wr(8'h2E, 8'h30);
      chk("R4 od low oe", pad_oe[3], 1);
      chk("R4 od low out", pad_out[3], 0);
      wr(8'h2E, 8'h21);
      chk("R3 pp oe", pad_oe[3], 1);
      chk("R3 pp out", pad_out[3], 1);
      wr(8'h2E, 8'h01);
      chk("R3 input oe", pad_oe[3], 0);
      wr(8'h2E, 8'h0E);
      chk("R5 pull_en", pull_en[3], 1);
      chk("R5 pull_sel", pull_sel[7:6], 2'b11);
      chk("R5 pull_sel pin15", pull_sel[31:30], 2'b10);
      chk("R5 pull_en pin15", pull_en[15], 0);

      // R6 both-edge on pin 3, unmasked (mask 0xA5 bit 3 clear)
      pin_in[3] = 1'b1;
      wait_n(3);
      rd_chk("R6 both rise", 8'h0B, 8'h08);
      chk("R9 irq latency", host_irq, 0);
      wait_n(1);
      chk("R9 irq asserted", host_irq, 1);
      rd_chk("R2 level read", 8'h36, 8'h07);
      wr(8'h0B, 8'h00);
      rd_chk("R7 zero write", 8'h0B, 8'h08);
      wr(8'h0B, 8'h08);
      rd_chk("R7 cleared", 8'h0B, 8'h00);
      wait_n(1);
      chk("R9 irq dropped", host_irq, 0);

      // R6 falling only
      wr(8'h36, 8'h02);
      pin_in[3] = 1'b0;
      wait_n(3);
      rd_chk("R6 fall seen", 8'h0B, 8'h08);
      wr(8'h0B, 8'h08);
      pin_in[3] = 1'b1;
      wait_n(4);
      rd_chk("R6 fall ignores rise", 8'h0B, 8'h00);

      // R6 rising only
      wr(8'h36, 8'h04);
      pin_in[3] = 1'b0;
      wait_n(4);
      rd_chk("R6 rise ignores fall", 8'h0B, 8'h00);
      pin_in[3] = 1'b1;
      wait_n(3);
      rd_chk("R6 rise seen", 8'h0B, 8'h08);
      wr(8'h0B, 8'h08);

      // R6 disabled
      wr(8'h36, 8'h00);
      pin_in[3] = 1'b0;
      wait_n(4);
      pin_in[3] = 1'b1;
      wait_n(4);
      rd_chk("R6 disabled", 8'h0B, 8'h00);
      chk("R6 disabled irq", host_irq, 0);

      // R9 masked pin 10 (bank 1 bit 2) still sets pending
      wr(8'h1A, 8'h04);
      pin_in[10] = 1'b1;
      wait_n(4);
      rd_chk("R9 masked pending", 8'h0C, 8'h04);
      chk("R9 masked irq", host_irq, 0);
      // R10 standby mask (0x3C has bit 2) does not gate
      wr(8'h1A, 8'h00);
      wait_n(1);
      chk("R10 standby no gate", host_irq, 1);
      wr(8'h1C, 8'hFF);
      wait_n(1);
      chk("R10 standby full", host_irq, 1);
      rd_chk("R10 standby read", 8'h1C, 8'hFF);

      // R8 clearing write lands in the capture cycle of a new edge
      pin_in[10] = 1'b0;
      wait_n(4);
      pin_in[10] = 1'b1;
      wait_n(2);
      wr(8'h0C, 8'h04);
      rd_chk("R8 set wins", 8'h0C, 8'h04);
      wr(8'h0C, 8'h04);
      rd_chk("R7 bank1 clear", 8'h0C, 8'h00);

      // R11 reset again
      rst_n = 1'b0;
      wait_n(1);
      rst_n = 1'b1;
      wait_n(1);
      rd_chk("R11 ctl after reset", 8'h2E, 8'h00);
      rd_chk("R11 mode after reset", 8'h45, 8'h00);
      rd_chk("R11 standby after reset", 8'h1C, 8'h00);
      chk("R11 oe after reset", pad_oe, 0);
      chk("R11 irq after reset", host_irq, 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule